// File: doc/BRIEF.md
# Capture-Compare Timer Channel with Clear-Only Status Flags

This block is a single timer channel built around a free-running up-counter. It has a set of general registers. A mode bit chooses, for each general register, whether it records the counter value when a capture pulse arrives or raises an event when the counter steps onto the stored value. Every general register owns one event flag, and the counter owns one wrap flag. All of these flags sit in an 8-bit status byte.

Software reaches the counter, the mode bits, the general registers and the status byte through a small synchronous register bus. The bus has a select, a read strobe, a write strobe, an address and a data word, and the read data is combinational. The status flags use a handshake that clears only. Software must first read the status byte while a flag is 1, and then write 0 to that bit. A write of 0 without that earlier read does nothing. A write of 1 never sets a flag.

Register map:

| Address | Content |
|---------|---------|
| 0 | counter |
| 1 | mode bits: bit i = 1 puts general register i in compare mode, 0 puts it in capture mode |
| 2 | status byte |
| 4 + i | general register i |

Top module: `capcmp_timer`

## Requirements
- R1: While `cnt_en` is high, the counter increases by one at each clock edge and wraps from 0xFFFF to 0x0000. A bus write to address 0 loads `bus_wdata` instead, even when `cnt_en` is high.
- R2: When general register i is in capture mode (mode bit i = 0) and `cap_pulse[i]` is high at an edge, the register takes the counter value held before that edge, and its flag is set at the same edge.
- R3: The wrap flag (status bit 7) is set at the edge where the counter steps from 0xFFFF to 0x0000 by counting.
- R4: When general register i is in compare mode (mode bit i = 1), its flag is set one edge after the counter has stepped by counting onto a value equal to the register. An equal value reached without a counting step raises no flag.
- R5: Writing 1 to a status bit never sets that flag and leaves both the flag and its read-armed state unchanged.
- R6: A flag clears only when a write of 0 to its bit comes after a status read made while that flag was 1. A write of 0 with no such read leaves the flag at 1.
- R7: If a set event and a valid clear of the same flag occur in the same cycle, the flag ends at 1.
- R8: After reset, the counter, the mode bits, the general registers and all flags read 0.
- R9: Status bit 7 is the wrap flag and bits 3..6 are the flags of general registers 0..3. Bits 0..2 always read 0.
- R10: The read-armed state of a flag is used up by the next write of 0 to that bit. A status read made while the flag is 0 does not arm it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, rising edge active |
| rst_n | input | 1 | synchronous reset, active low |
| cnt_en | input | 1 | count enable |
| cap_pulse | input | NUM_GR | one-cycle synchronous capture pulses, one per general register |
| bus_sel | input | 1 | bus select |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 3 | register address |
| bus_wdata | input | CNT_W | write data |
| bus_rdata | output | CNT_W | combinational read data |
| count_o | output | CNT_W | current counter value |
| status_o | output | 8 | current status byte |

## Verification
The assertions assume that capture pulses are synchronous to the clock and last one cycle. They also assume that a bus access asserts either the read strobe or the write strobe, never both. The bench drives every input at the falling edge and never raises both strobes together. It holds each strobe and pulse for exactly one cycle, so every event that an assertion follows starts and ends inside one clock period.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
   localparam int ADDR_W   = 3;
   localparam int STAT_W   = 8;
   localparam int WRAP_POS = 7;
   localparam int EVT_BASE = 3;
   localparam int MAX_GR   = 4;

   localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_GR0   = 3'd4;

   typedef enum logic {
      GR_CAPTURE = 1'b0,
      GR_COMPARE = 1'b1
   } gr_mode_e;
endpackage

// File: rtl/ccs_counter.sv
module ccs_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             stepped_q,
   output logic             wrap_evt
);
   localparam logic [CNT_W-1:0] TOP = '1;

   if (CNT_W < 2) begin : g_bad_width
      $error("ccs_counter: CNT_W must be at least 2");
   end

   logic step;
   assign step     = en & ~ld;
   assign wrap_evt = step & (cnt_q == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         stepped_q <= 1'b0;
      end else begin
         stepped_q <= step;
         if (ld)
            cnt_q <= ld_val;
         else if (en)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: counting step and load priority
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ld) |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_load_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(ld_val)));
   // R3: a wrap event leaves the counter at zero
   p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> (cnt_q == '0));
endmodule

// File: rtl/ccs_gr_slot.sv
module ccs_gr_slot #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_cmp,
   input  logic             cap_pulse,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic [CNT_W-1:0] cnt,
   input  logic             stepped,
   output logic [CNT_W-1:0] gr_q,
   output logic             evt
);
   logic cap_take;
   logic cmp_hit;

   assign cap_take = ~is_cmp & cap_pulse;
   assign cmp_hit  = is_cmp & stepped & (cnt == gr_q);
   assign evt      = cap_take | cmp_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gr_q <= '0;
      else if (cap_take)
         gr_q <= cnt;
      else if (wr_en)
         gr_q <= wr_val;
   end

   // R2: a capture copies the counter value seen at that edge
   p_capture_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_cmp && cap_pulse) |=> (gr_q == $past(cnt)));
   // R4: in compare mode, no event without a counting step
   p_cmp_needs_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmp && !stepped) |-> !evt);
endmodule

// File: rtl/ccs_status_flags.sv
module ccs_status_flags #(
   parameter int NFLAG = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_vec,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [NFLAG-1:0] wr_bits,
   output logic [NFLAG-1:0] flag_q
);
   if (NFLAG < 1) begin : g_bad_count
      $error("ccs_status_flags: NFLAG must be at least 1");
   end

   logic [NFLAG-1:0] armed_q;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic zero_wr;
      logic clr;
      assign zero_wr = wr_stb & ~wr_bits[i];
      assign clr     = zero_wr & armed_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q[i]  <= 1'b0;
            armed_q[i] <= 1'b0;
         end else begin
            flag_q[i] <= set_vec[i] | (flag_q[i] & ~clr);
            if (zero_wr)
               armed_q[i] <= 1'b0;
            else if (rd_stb && flag_q[i])
               armed_q[i] <= 1'b1;
         end
      end

      // R5: a flag only rises from a hardware set event
      p_rise_needs_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_q[i]) |-> $past(set_vec[i]));
      // R6: a flag only falls after an armed write of zero
      p_fall_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag_q[i]) |-> $past(armed_q[i] && wr_stb && !wr_bits[i]));
      // R7: a set event always leaves the flag at one
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> flag_q[i]);
      // R10: a zero write consumes the armed state
      p_arm_used_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && !wr_bits[i]) |=> !armed_q[i]);
   end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
   import ccs_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_GR = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cnt_en,
   input  logic [NUM_GR-1:0]     cap_pulse,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [CNT_W-1:0]      bus_wdata,
   output logic [CNT_W-1:0]      bus_rdata,
   output logic [CNT_W-1:0]      count_o,
   output logic [STAT_W-1:0]     status_o
);
   localparam int NFLAG    = NUM_GR + 1;
   localparam int WRAP_IDX = NUM_GR;

   if (NUM_GR < 1 || NUM_GR > MAX_GR) begin : g_bad_gr
      $error("capcmp_timer: NUM_GR must be in 1..4");
   end
   if (CNT_W < STAT_W) begin : g_bad_data
      $error("capcmp_timer: CNT_W must hold the status byte");
   end

   logic wr_stb, rd_stb;
   logic wr_count, wr_mode, wr_stat, rd_stat;
   assign wr_stb   = bus_sel & bus_wr;
   assign rd_stb   = bus_sel & bus_rd & ~bus_wr;
   assign wr_count = wr_stb & (bus_addr == ADR_COUNT);
   assign wr_mode  = wr_stb & (bus_addr == ADR_MODE);
   assign wr_stat  = wr_stb & (bus_addr == ADR_STAT);
   assign rd_stat  = rd_stb & (bus_addr == ADR_STAT);

   logic [CNT_W-1:0] cnt;
   logic             stepped;
   logic             wrap_evt;

   ccs_counter #(.CNT_W(CNT_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cnt_en),
      .ld        (wr_count),
      .ld_val    (bus_wdata),
      .cnt_q     (cnt),
      .stepped_q (stepped),
      .wrap_evt  (wrap_evt)
   );

   logic [NUM_GR-1:0] mode_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (wr_mode)
         mode_q <= bus_wdata[NUM_GR-1:0];
   end

   logic [CNT_W-1:0] gr_q [NUM_GR];
   logic [NFLAG-1:0] set_vec;
   logic [NFLAG-1:0] wr_bits;
   logic [NFLAG-1:0] flag_q;

   for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
      logic wr_this;
      assign wr_this = wr_stb & (bus_addr == ADR_GR0 + ADDR_W'(i));
      ccs_gr_slot #(.CNT_W(CNT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .is_cmp    (mode_q[i] == GR_COMPARE),
         .cap_pulse (cap_pulse[i]),
         .wr_en     (wr_this),
         .wr_val    (bus_wdata),
         .cnt       (cnt),
         .stepped   (stepped),
         .gr_q      (gr_q[i]),
         .evt       (set_vec[i])
      );
      assign wr_bits[i] = bus_wdata[EVT_BASE+i];
   end
   assign set_vec[WRAP_IDX] = wrap_evt;
   assign wr_bits[WRAP_IDX] = bus_wdata[WRAP_POS];

   ccs_status_flags #(.NFLAG(NFLAG)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .rd_stb  (rd_stat),
      .wr_stb  (wr_stat),
      .wr_bits (wr_bits),
      .flag_q  (flag_q)
   );

   always_comb begin
      status_o           = '0;
      status_o[WRAP_POS] = flag_q[WRAP_IDX];
      for (int i = 0; i < NUM_GR; i++)
         status_o[EVT_BASE+i] = flag_q[i];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_COUNT: bus_rdata = cnt;
         ADR_MODE:  bus_rdata[NUM_GR-1:0] = mode_q;
         ADR_STAT:  bus_rdata[STAT_W-1:0] = status_o;
         default: begin
            for (int i = 0; i < NUM_GR; i++)
               if (bus_addr == ADR_GR0 + ADDR_W'(i))
                  bus_rdata = gr_q[i];
         end
      endcase
   end

   assign count_o = cnt;

   // R9: the low status bits never carry a flag
   p_low_bits_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[EVT_BASE-1:0] == '0);
   // R3: the wrap flag rises only after the counter reached zero by counting
   p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[WRAP_POS]) |-> (count_o == '0 && $past(cnt_en)));
endmodule

// File: tb/tb_capcmp_timer.sv
module tb_capcmp_timer;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cnt_en = 1'b0;
   logic [NG-1:0] cap_pulse = '0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata, count_o;
   logic [7:0]    status_o;

   capcmp_timer #(.CNT_W(16), .NUM_GR(NG)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_pulse(cap_pulse),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_o(count_o),
      .status_o(status_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_cnt;
   int m_gr [NG];
   bit m_mode [NG];
   bit m_flag [8];
   bit m_arm [8];
   bit m_set [8];
   bit m_step;
   bit w_cnt, w_mode, w_stat, r_stat, clr;

   function automatic int exp_status();
      int s = 0;
      for (int b = 0; b < 8; b++) if (m_flag[b]) s |= (1 << b);
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_step = 0;
         for (int i = 0; i < NG; i++) begin m_gr[i] = 0; m_mode[i] = 0; end
         for (int b = 0; b < 8; b++) begin m_flag[b] = 0; m_arm[b] = 0; end
      end else begin
         w_cnt  = bus_sel && bus_wr && bus_addr == 0;
         w_mode = bus_sel && bus_wr && bus_addr == 1;
         w_stat = bus_sel && bus_wr && bus_addr == 2;
         r_stat = bus_sel && bus_rd && !bus_wr && bus_addr == 2;
         for (int b = 0; b < 8; b++) m_set[b] = 0;
         m_set[7] = cnt_en && !w_cnt && m_cnt == 16'hFFFF;
         for (int i = 0; i < NG; i++) begin
            if (m_mode[i]) m_set[3+i] = m_step && m_cnt == m_gr[i];
            else           m_set[3+i] = cap_pulse[i];
         end
         for (int i = 0; i < NG; i++) begin
            if (!m_mode[i] && cap_pulse[i]) m_gr[i] = m_cnt;
            else if (bus_sel && bus_wr && bus_addr == 3'(4+i)) m_gr[i] = bus_wdata;
         end
         for (int b = 3; b < 8; b++) begin
            clr = 0;
            if (w_stat && !bus_wdata[b]) begin clr = m_arm[b]; m_arm[b] = 0; end
            else if (r_stat && m_flag[b]) m_arm[b] = 1;
            m_flag[b] = m_set[b] | (m_flag[b] & !clr);
         end
         if (w_mode) for (int i = 0; i < NG; i++) m_mode[i] = bus_wdata[i];
         m_step = cnt_en && !w_cnt;
         if (w_cnt) m_cnt = bus_wdata;
         else if (cnt_en) m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 counter vs model", count_o, m_cnt);
         check("R9 status byte vs model", status_o, exp_status());
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic pulse(input logic [NG-1:0] m);
      @(negedge clk); cap_pulse = m;
      @(negedge clk); cap_pulse = '0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      logic [15:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      check("R8 status after reset", status_o, 0);
      check("R8 counter after reset", count_o, 0);
      bus_read(3'd4, v); check("R8 GR0 after reset", v, 0);
      bus_read(3'd1, v); check("R8 mode after reset", v, 0);

      // R1 counting and load priority
      cnt_en = 1;
      repeat (10) @(negedge clk);
      bus_write(3'd0, 16'h0100); #1;
      check("R1 load wins over count", count_o, 16'h0100);

      // R2 capture into GR0
      pulse(4'b0001);
      bus_read(3'd4, v); check("R2 captured value", v, m_gr[0]);
      #1 check("R9 capture flag in bit 3", status_o[3], 1);

      // R6 plain zero write without read
      bus_write(3'd2, 16'h0000); #1;
      check("R6 zero write without read keeps flag", status_o[3], 1);
      bus_read(3'd2, v); check("R6 read shows flag", v[3], 1);
      bus_write(3'd2, 16'h0000); #1;
      check("R6 armed zero write clears flag", status_o[3], 0);

      // R5 write of ones
      bus_write(3'd2, 16'h00FF); #1;
      check("R5 ones write sets nothing", status_o, 0);
      pulse(4'b0100);
      bus_read(3'd2, v);
      bus_write(3'd2, 16'h00FF); #1;
      check("R5 ones write keeps flag", status_o[5], 1);
      bus_write(3'd2, 16'h0000); #1;
      check("R5 arm survives ones write", status_o[5], 0);

      // R10 read while zero does not arm; arm is consumed
      bus_read(3'd2, v);
      pulse(4'b0001);
      bus_write(3'd2, 16'h0000); #1;
      check("R10 read at zero does not arm", status_o[3], 1);
      bus_read(3'd2, v);
      bus_write(3'd2, 16'h0000);
      pulse(4'b0001);
      bus_write(3'd2, 16'h0000); #1;
      check("R10 arm consumed by earlier write", status_o[3], 1);

      // R7 set and clear together
      bus_read(3'd2, v);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 16'h0000; cap_pulse = 4'b0001;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; cap_pulse = '0; #1;
      check("R7 set wins over clear", status_o[3], 1);
      bus_read(3'd2, v);
      bus_write(3'd2, 16'h0000);

      // R4 compare mode
      cnt_en = 0;
      bus_write(3'd1, 16'h0002);
      c = count_o;
      bus_write(3'd5, c);
      repeat (3) @(negedge clk); #1;
      check("R4 equal without step gives no flag", status_o[4], 0);
      bus_write(3'd5, c + 16'd3);
      cnt_en = 1;
      repeat (6) @(negedge clk); #1;
      check("R4 compare match flag", status_o[4], 1);

      // R3 wrap
      bus_write(3'd0, 16'hFFFD);
      repeat (5) @(negedge clk); #1;
      check("R3 wrap flag", status_o[7], 1);
      check("R9 low bits zero", status_o[2:0], 0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule